// File: doc/BRIEF.md
# Three-level seven-segment PWM sequencer

This block drives the twelve switch gates of a three-phase T-type bridge in which every phase leg has four switches and can sit at one of three levels: the positive rail (+Udc/2), the neutral point (0) or the negative rail (-Udc/2). A triangular carrier counts up from zero to half the sampling period and back down again. Three compare thresholds, derived from three dwell times, split each half of the carrier into four segments. The segments therefore run as the mirrored sequence 0,1,2,3,2,1,0 within each period. Segment 0 is meant to carry the negative short vector, so a typical table reads ONN, PNN, PON, POO.

A four-entry vector table supplies the target level of every phase for each segment. A phase moves to its target one cycle later, but only between adjacent levels. A request to jump straight between the two rails, or an undefined code, leaves the phase where it is and raises an error pulse. Each gate then passes through a dead-time stage. Turn-on waits a programmable number of cycles, while turn-off acts at once, so the clamping switches of a leg never conduct together with the outer switches.

The dwell times, the period, the table and the dead time are sampled only when the carrier returns to zero. The block cannot tear a period in half. A strobe marks the first cycle of each period so that an upstream calculator can deliver the next set of values.

Top module: `tl7_pwm_seq`

## Requirements
- R1: While reset is applied, and for the two clock edges after it is released, all twelve gates and the error output are low.
- R2: The carrier counts 0,1,...,H and then H-1,...,1, so a period lasts 2H cycles, where H = floor(Ts/2). With H = 0 the carrier stays at 0. The strobe is high exactly in the cycles where the carrier is 0.
- R3: Ts, the three dwell times, the table and the dead time are sampled only at the clock edge where the carrier returns to 0. Changes at any other time have no effect on the outputs until then.
- R4: With A1 = floor(T1/2), A2 = A1 + floor(T2/2) and A3 = A2 + floor(T3/2), the segment is 0 while the carrier is below A1, 1 while below A2, 2 while below A3, and 3 otherwise. The segment order is therefore symmetric about the carrier peak.
- R5: Table bits [6k+2p+1 : 6k+2p] hold the level of phase p (a=0, b=1, c=2) for segment k. The codes are 0 = negative rail (N), 1 = neutral (O), 2 = positive rail (P) and 3 = undefined.
- R6: A phase takes its target level on the clock edge after the target is presented. Gate bit 4p+s-1 drives switch s of phase p. The switch demands are: P gives switches 1..4 = 1,1,0,0; O gives 0,1,1,0; N gives 0,0,1,1.
- R7: A gate whose demand falls goes low one cycle after the level change. A gate whose demand rises goes high 1+D cycles after the level change, where D is the dead-time count.
- R8: A target that would move a phase directly between P and N, or a target coded 3, leaves that phase's level unchanged and drives the error output high in the following cycle.
- R9: Within a phase, switches 1 and 3 are never on together, and switches 2 and 4 are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ts_i | input | CNT_W | Sampling period in clock cycles |
| t1_i | input | CNT_W | Dwell time of segment 0 (full period, cycles) |
| t2_i | input | CNT_W | Dwell time of segment 1 |
| t3_i | input | CNT_W | Dwell time of segment 2 |
| seg_tbl_i | input | 24 | Per-segment phase levels, 2 bits per phase |
| dt_i | input | DT_W | Dead-time count applied to turn-on |
| gate_o | output | 12 | Switch gates, 4 per phase, phase a in the low bits |
| sync_o | output | 1 | High in the first cycle of each period |
| err_o | output | 1 | Pulse when a requested level change is refused |

## Verification
The shoot-through and turn-on properties assume that the switch demand of each leg comes from a single level code. They therefore depend only on the level registers being free of X after reset, which the reset sequence ensures. The counting and hold properties assume the period input fits in CNT_W bits. The stimulus keeps Ts, the dwell times and the dead time well below their widths, including odd periods, periods of 1 and 2, and dwell sums that exceed half the period. Dwell times, period and table are changed deliberately in the middle of a period, and tables with rail-to-rail jumps and undefined codes are applied, so that the refusal path and the hold-until-zero rule are both exercised.

// File: rtl/tlp_pkg.sv
package tlp_pkg;

  localparam int PHASES    = 3;
  localparam int SW_PER_PH = 4;
  localparam int SEGS      = 4;
  localparam int LVL_W     = 2;
  localparam int ENT_W     = PHASES * LVL_W;
  localparam int TBL_W     = SEGS * ENT_W;
  localparam int GATES     = PHASES * SW_PER_PH;

  typedef enum logic [LVL_W-1:0] {
    LVL_N   = 2'd0,
    LVL_O   = 2'd1,
    LVL_P   = 2'd2,
    LVL_BAD = 2'd3
  } lvl_e;

  // bit 0 = switch 1 (outer, positive rail) ... bit 3 = switch 4
  function automatic logic [SW_PER_PH-1:0] lvl_to_sw(input lvl_e lvl);
    logic [SW_PER_PH-1:0] sw;
    case (lvl)
      LVL_P:   sw = 4'b0011;
      LVL_O:   sw = 4'b0110;
      LVL_N:   sw = 4'b1100;
      default: sw = 4'b0000;
    endcase
    return sw;
  endfunction

  function automatic logic step_ok(input lvl_e cur, input lvl_e nxt);
    logic ok;
    if (nxt == LVL_BAD)                             ok = 1'b0;
    else if (cur == LVL_P && nxt == LVL_N)          ok = 1'b0;
    else if (cur == LVL_N && nxt == LVL_P)          ok = 1'b0;
    else                                            ok = 1'b1;
    return ok;
  endfunction

endpackage

// File: rtl/tlp_rst_sync.sv
module tlp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];

endmodule

// File: rtl/tlp_carrier.sv
module tlp_carrier #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] ts_i,
  input  logic [CNT_W-1:0] t1_i,
  input  logic [CNT_W-1:0] t2_i,
  input  logic [CNT_W-1:0] t3_i,
  output logic             load_o,
  output logic             zero_o,
  output logic [1:0]       seg_o
);

  localparam int THR_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic [CNT_W-1:0] half_q, half_d;
  logic [THR_W-1:0] thr1_q, thr1_d;
  logic [THR_W-1:0] thr2_q, thr2_d;
  logic [THR_W-1:0] thr3_q, thr3_d;
  logic [THR_W-1:0] cnt_x;
  logic             load;

  // carrier next state
  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (up_q && (cnt_q < half_q)) begin
      cnt_d = cnt_q + 1'b1;
    end else if (cnt_q <= CNT_W'(1)) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
      up_d  = 1'b0;
    end
  end

  assign load = (cnt_d == '0);

  // threshold next state, enabled only at the period boundary
  always_comb begin
    half_d = half_q;
    thr1_d = thr1_q;
    thr2_d = thr2_q;
    thr3_d = thr3_q;
    if (load) begin
      half_d = ts_i >> 1;
      thr1_d = {1'b0, t1_i} >> 1;
      thr2_d = ({1'b0, t1_i} >> 1) + ({1'b0, t2_i} >> 1);
      thr3_d = ({1'b0, t1_i} >> 1) + ({1'b0, t2_i} >> 1) + ({1'b0, t3_i} >> 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      half_q <= '0;
      thr1_q <= '0;
      thr2_q <= '0;
      thr3_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      up_q   <= up_d;
      half_q <= half_d;
      thr1_q <= thr1_d;
      thr2_q <= thr2_d;
      thr3_q <= thr3_d;
    end
  end

  assign cnt_x = {1'b0, cnt_q};

  always_comb begin
    if (cnt_x < thr1_q)      seg_o = 2'd0;
    else if (cnt_x < thr2_q) seg_o = 2'd1;
    else if (cnt_x < thr3_q) seg_o = 2'd2;
    else                     seg_o = 2'd3;
  end

  assign load_o = load;
  assign zero_o = (cnt_q == '0);

  // R2: below the peak the carrier advances by exactly one per cycle
  p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && (cnt_q < half_q)) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R2: the carrier never sits below zero on its way down
  p_down_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_q) |-> (cnt_q != '0));

  // R3: the period and thresholds stay frozen between boundaries
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> ($stable(half_q) && $stable(thr3_q)));

endmodule

// File: rtl/tlp_phase_fsm.sv
module tlp_phase_fsm
  import tlp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  lvl_e tgt_i,
  output lvl_e lvl_o,
  output logic err_o
);

  lvl_e lvl_q, lvl_d;
  logic err_q, err_d;

  always_comb begin
    lvl_d = lvl_q;
    err_d = 1'b0;
    if (tgt_i != lvl_q) begin
      if (step_ok(lvl_q, tgt_i)) lvl_d = tgt_i;
      else                       err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_O;
      err_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      err_q <= err_d;
    end
  end

  assign lvl_o = lvl_q;
  assign err_o = err_q;

  // R8: a phase on the positive rail never lands on the negative rail next
  p_no_jump_pn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LVL_P) |=> (lvl_q != LVL_N));

  // R8: the reverse jump is also refused
  p_no_jump_np_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LVL_N) |=> (lvl_q != LVL_P));

  // R8: a refused request leaves the level untouched
  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(lvl_q));

  // R5: the undefined code is never stored
  p_no_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q != LVL_BAD);

endmodule

// File: rtl/tlp_deadtime.sv
module tlp_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dem_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            gate_o
);

  logic            gate_q, gate_d;
  logic [DT_W-1:0] wait_q, wait_d;

  always_comb begin
    gate_d = 1'b0;
    wait_d = '0;
    if (dem_i) begin
      if (gate_q || (wait_q >= dt_i)) begin
        gate_d = 1'b1;
      end else begin
        wait_d = wait_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      wait_q <= '0;
    end else begin
      gate_q <= gate_d;
      wait_q <= wait_d;
    end
  end

  assign gate_o = gate_q;

  // R7: removal of the demand turns the gate off on the next edge
  p_turnoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dem_i) |=> (!gate_q));

  // R7: a gate only rises after its demand was already present
  p_turnon_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> $past(dem_i));

endmodule

// File: rtl/tl7_pwm_seq.sv
module tl7_pwm_seq
  import tlp_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   ts_i,
  input  logic [CNT_W-1:0]   t1_i,
  input  logic [CNT_W-1:0]   t2_i,
  input  logic [CNT_W-1:0]   t3_i,
  input  logic [TBL_W-1:0]   seg_tbl_i,
  input  logic [DT_W-1:0]    dt_i,
  output logic [GATES-1:0]   gate_o,
  output logic               sync_o,
  output logic               err_o
);

  localparam logic [TBL_W-1:0] TBL_RST = {(SEGS*PHASES){2'b01}};

  logic               rst_i;
  logic               load;
  logic [1:0]         seg;
  logic [TBL_W-1:0]   tbl_q, tbl_d;
  logic [DT_W-1:0]    dt_q, dt_d;
  lvl_e               tgt [PHASES];
  lvl_e               lvl [PHASES];
  logic [PHASES-1:0]  ph_err;
  logic [GATES-1:0]   demand;

  tlp_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  tlp_carrier #(.CNT_W(CNT_W)) i_carrier (
    .clk    (clk),
    .rst_n  (rst_i),
    .ts_i   (ts_i),
    .t1_i   (t1_i),
    .t2_i   (t2_i),
    .t3_i   (t3_i),
    .load_o (load),
    .zero_o (sync_o),
    .seg_o  (seg)
  );

  // table and dead time share the carrier's boundary enable
  always_comb begin
    tbl_d = tbl_q;
    dt_d  = dt_q;
    if (load) begin
      tbl_d = seg_tbl_i;
      dt_d  = dt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      tbl_q <= TBL_RST;
      dt_q  <= '0;
    end else begin
      tbl_q <= tbl_d;
      dt_q  <= dt_d;
    end
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    always_comb begin
      int idx;
      idx    = int'(seg) * ENT_W + p * LVL_W;
      tgt[p] = lvl_e'(tbl_q[idx +: LVL_W]);
    end

    tlp_phase_fsm i_fsm (
      .clk   (clk),
      .rst_n (rst_i),
      .tgt_i (tgt[p]),
      .lvl_o (lvl[p]),
      .err_o (ph_err[p])
    );

    assign demand[p*SW_PER_PH +: SW_PER_PH] = lvl_to_sw(lvl[p]);

    // R9: outer and clamp switches of one leg never conduct together
    p_no_shoot_r9: assert property (@(posedge clk) disable iff (!rst_i)
      !(gate_o[p*SW_PER_PH] && gate_o[p*SW_PER_PH+2]) &&
      !(gate_o[p*SW_PER_PH+1] && gate_o[p*SW_PER_PH+3]));
  end

  for (genvar g = 0; g < GATES; g++) begin : g_gate
    tlp_deadtime #(.DT_W(DT_W)) i_dt (
      .clk    (clk),
      .rst_n  (rst_i),
      .dem_i  (demand[g]),
      .dt_i   (dt_q),
      .gate_o (gate_o[g])
    );
  end

  assign err_o = |ph_err;

endmodule

// File: tb/test_tl7_pwm_seq.sv
module test_tl7_pwm_seq;

  localparam int CW = 12;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] ts, t1, t2, t3;
  logic [23:0]   tbl;
  logic [DW-1:0] dt;
  logic [11:0]   gate;
  logic          sync, err;

  tl7_pwm_seq #(.CNT_W(CW), .DT_W(DW)) i_tl7_pwm_seq (
    .clk(clk), .rst_n(rst_n), .ts_i(ts), .t1_i(t1), .t2_i(t2), .t3_i(t3),
    .seg_tbl_i(tbl), .dt_i(dt), .gate_o(gate), .sync_o(sync), .err_o(err)
  );

  always #10 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  int    err_seen = 0;
  string tag = "R1";

  // behavioural reference state
  int       m_rc = 0;
  int       m_cnt = 0, m_up = 1, m_h = 0;
  int       m_a1 = 0, m_a2 = 0, m_a3 = 0, m_dt = 0;
  logic [23:0] m_tbl = 24'h555555;
  int       m_st [3] = '{1, 1, 1};
  int       m_err = 0;
  int       m_g [12];
  int       m_dc [12];

  function automatic int sw_of(input int lv);
    case (lv)
      2: return 4'b0011;
      1: return 4'b0110;
      0: return 4'b1100;
      default: return 0;
    endcase
  endfunction

  function automatic bit legal(input int cur, input int nx);
    if (nx == 3) return 1'b0;
    if ((cur == 2 && nx == 0) || (cur == 0 && nx == 2)) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_rc = 0;
    if (m_rc < 2) begin
      m_cnt = 0; m_up = 1; m_h = 0; m_a1 = 0; m_a2 = 0; m_a3 = 0; m_dt = 0;
      m_tbl = 24'h555555; m_err = 0;
      for (int p = 0; p < 3; p++) m_st[p] = 1;
      for (int i = 0; i < 12; i++) begin m_g[i] = 0; m_dc[i] = 0; end
      if (rst_n) m_rc = m_rc + 1;
    end else begin
      int seg, ncnt, nup;
      // gates from the present levels
      for (int i = 0; i < 12; i++) begin
        int d;
        d = (sw_of(m_st[i/4]) >> (i%4)) & 1;
        if (d == 0) begin m_g[i] = 0; m_dc[i] = 0; end
        else if (m_g[i] == 1 || m_dc[i] >= m_dt) begin m_g[i] = 1; m_dc[i] = 0; end
        else m_dc[i] = m_dc[i] + 1;
      end
      // segment and level update
      if (m_cnt < m_a1) seg = 0;
      else if (m_cnt < m_a2) seg = 1;
      else if (m_cnt < m_a3) seg = 2;
      else seg = 3;
      m_err = 0;
      for (int p = 0; p < 3; p++) begin
        int t;
        t = int'((m_tbl >> (seg*6 + p*2)) & 24'h3);
        if (t != m_st[p]) begin
          if (legal(m_st[p], t)) m_st[p] = t;
          else m_err = 1;
        end
      end
      // carrier
      if (m_up == 1 && m_cnt < m_h) begin ncnt = m_cnt + 1; nup = 1; end
      else if (m_cnt <= 1) begin ncnt = 0; nup = 1; end
      else begin ncnt = m_cnt - 1; nup = 0; end
      m_cnt = ncnt; m_up = nup;
      if (ncnt == 0) begin
        m_h  = int'(ts) / 2;
        m_a1 = int'(t1) / 2;
        m_a2 = m_a1 + int'(t2) / 2;
        m_a3 = m_a2 + int'(t3) / 2;
        m_tbl = tbl;
        m_dt = int'(dt);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    int exp_g;
    exp_g = 0;
    for (int i = 0; i < 12; i++) exp_g = exp_g | (m_g[i] << i);
    check(int'(gate) == exp_g, tag, "gate_o (R6/R7)", int'(gate), exp_g);
    check(sync == (m_cnt == 0), tag, "sync_o (R2)", int'(sync), int'(m_cnt == 0));
    check(int'(err) == m_err, tag, "err_o (R8)", int'(err), m_err);
    for (int p = 0; p < 3; p++) begin
      bit bad;
      bad = (gate[4*p] && gate[4*p+2]) || (gate[4*p+1] && gate[4*p+3]);
      check(!bad, "R9", "shoot-through pair", int'(gate[4*p +: 4]), 0);
    end
    if (err) err_seen++;
    cyc++;
    if (cyc >= 200000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
      finish_run();
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_sync();
    do @(negedge clk); while (!sync);
  endtask

  initial begin
    ts = 12'd40; t1 = 12'd8; t2 = 12'd10; t3 = 12'd12; dt = 8'd2;
    // segments ONN, PNN, PON, POO (codes N=0 O=1 P=2, phase a in low bits)
    tbl = {6'b010110, 6'b000110, 6'b000010, 6'b000001};
    tag = "R1";
    wait_cyc(4);
    check(gate == 12'h000, "R1", "gates in reset", int'(gate), 0);
    check(err == 1'b0, "R1", "err in reset", int'(err), 0);
    rst_n = 1'b1;
    wait_cyc(1);
    check(gate == 12'h000, "R1", "gates after release", int'(gate), 0);

    tag = "R4";
    wait_cyc(200);

    tag = "R3";
    wait_sync();
    wait_cyc(5);
    ts = 12'd30; t1 = 12'd4; t2 = 12'd20; t3 = 12'd6; dt = 8'd1;
    wait_cyc(3);
    ts = 12'd46; t1 = 12'd6; t2 = 12'd14; t3 = 12'd9;
    wait_cyc(200);

    tag = "R7";
    dt = 8'd0;
    wait_cyc(100);
    ts = 12'd80; dt = 8'd15;
    wait_cyc(300);

    tag = "R2";
    ts = 12'd7; t1 = 12'd2; t2 = 12'd2; t3 = 12'd2; dt = 8'd1;
    wait_cyc(60);
    ts = 12'd1;
    wait_cyc(10);
    ts = 12'd2;
    wait_cyc(10);
    ts = 12'd20; t1 = 12'd30; t2 = 12'd10; t3 = 12'd4;
    wait_cyc(60);

    tag = "R6";
    ts = 12'd40; t1 = 12'd8; t2 = 12'd10; t3 = 12'd12; dt = 8'd3;
    tbl = {4{6'b000110}};
    wait_cyc(120);
    // phase a at P (0011), b at O (0110), c at N (1100)
    check(gate == 12'hC63, "R5 R6", "static PON gate pattern", int'(gate), 'hC63);

    tag = "R8";
    err_seen = 0;
    tbl = {6'b000010, 6'b000010, 6'b000010, 6'b000000};
    wait_cyc(150);
    check(err_seen > 0, "R8", "rail-to-rail refusal seen", err_seen, 1);
    err_seen = 0;
    tbl = {4{6'b000011}};
    wait_cyc(80);
    check(err_seen > 0, "R8", "undefined code refusal seen", err_seen, 1);

    tag = "R4";
    tbl = {6'b010110, 6'b000110, 6'b000010, 6'b000001};
    wait_cyc(150);

    finish_run();
  end

endmodule